// File: doc/BRIEF.md
# Predicated Four-Way Interleaving Halfword Store Unit

This unit writes four source vectors of 16-bit elements to memory as packed four-halfword records. Record `e` holds element `e` of vector 0, then vector 1, vector 2 and vector 3, in that order. The records sit back to back starting at a base address plus a scaled signed immediate. The unit emits one halfword slot per cycle on a simple write port that has address, data, write enable and ready.

A governing predicate, with one bit per byte of vector length, marks which records are written. A record whose predicate element is clear still uses its eight bytes of address space and one cycle per slot, but no write is issued for it.

A one-cycle `start_i` pulse captures every operand. `busy_o` stays high while the unit walks the slots. `done_o` pulses for one cycle after the final slot.

Top module: `ilv4_store`

## Requirements
- R1: While reset is asserted, and after it, until the first accepted start, `busy_o`, `done_o` and `mem_we_o` are 0. Asserting reset during an operation returns the outputs to this state at once.
- R2: The first slot address is `base_i + sext(imm_i) * VLEN/2`, modulo 2^64. `imm_i` is a two's-complement 4-bit value (-8..7), so the offset is `imm_i` times four vectors of `VLEN/16` halfwords.
- R3: Slot k (k = 0 .. 4*VLEN/16-1) has element index e = k/4 and vector index r = k mod 4. Its address is the start address + 2k (mod 2^64). Its data is bits `[16e+15:16e]` of vector r (`vec0_i`..`vec3_i`).
- R4: Record e is active only when predicate bit 2e is 1. Odd predicate bits have no effect.
- R5: A slot in an inactive record issues no write (`mem_we_o` = 0), takes exactly one cycle, and the address still advances by 2.
- R6: A slot in an active record drives `mem_we_o` = 1 and advances only on a cycle with `mem_ready_i` = 1. While `mem_ready_i` is 0, the address, data and write enable stay unchanged.
- R7: After the last slot (e = VLEN/16-1, r = 3) advances, `busy_o` drops and `done_o` is 1 for exactly one cycle.
- R8: A start pulse while `busy_o` is 1 is ignored, and the running operation continues unchanged.
- R9: With no active records, no write is issued, and `done_o` still pulses after 4*VLEN/16 busy cycles.
- R10: `start_i` while idle captures base, immediate, predicate and the four vectors, and `busy_o` is 1 in the next cycle. Later input changes do not affect the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | 64 | Base byte address |
| imm_i | input | 4 | Signed immediate, in units of four vectors |
| pred_i | input | VLEN/8 | Governing predicate, one bit per vector byte |
| vec0_i | input | VLEN | Source vector 0 |
| vec1_i | input | VLEN | Source vector 1 |
| vec2_i | input | VLEN | Source vector 2 |
| vec3_i | input | VLEN | Source vector 3 |
| mem_ready_i | input | 1 | Memory accepts the current write |
| mem_addr_o | output | 64 | Byte address of the current slot |
| mem_data_o | output | 16 | Halfword of the current slot |
| mem_we_o | output | 1 | Write enable for the current slot |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory side never retracts acceptance: `mem_ready_i` is only sampled as a handshake while `mem_we_o` is high. They also assume that `start_i` is a synchronous input and is never treated as a request while the unit is busy. The bench drives all inputs on the falling edge. It toggles ready from an LFSR, including on inactive slots where ready must have no effect. It deliberately pulses start mid-run and scrambles every operand right after each start, so that the captured copies are the only source the design can use.

// File: rtl/ilv4_pkg.sv
package ilv4_pkg;
  localparam int unsigned HW_BITS = 16;
  localparam int unsigned NREG    = 4;

  typedef logic [63:0] addr_t;
  typedef logic [15:0] half_t;

  // base + sext(imm) * four vectors of halfwords, wrapping mod 2^64
  function automatic addr_t start_addr(addr_t base, logic [3:0] imm, int unsigned vlen);
    addr_t off;
    off = {{60{imm[3]}}, imm} * addr_t'(vlen / 2);
    return base + off;
  endfunction
endpackage

// File: rtl/ilv4_seq.sv
module ilv4_seq #(
  parameter int unsigned ELEMS = 8,
  localparam int unsigned EW   = $clog2(ELEMS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          step_i,
  output logic [EW-1:0] elem_o,
  output logic [1:0]    reg_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [EW-1:0] elem_q;
  logic [1:0]    reg_q;
  logic          busy_q, done_q, last_slot;

  assign last_slot = (elem_q == EW'(ELEMS - 1)) && (reg_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_q <= '0;
      reg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_i) begin
        elem_q <= '0;
        reg_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && step_i) begin
        if (last_slot) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          reg_q <= reg_q + 2'd1;
          if (reg_q == 2'd3) elem_q <= elem_q + EW'(1);
        end
      end
    end
  end

  assign elem_o = elem_q;
  assign reg_o  = reg_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/ilv4_addr_gen.sv
module ilv4_addr_gen
  import ilv4_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       step_i,
  input  addr_t      base_i,
  input  logic [3:0] imm_i,
  output addr_t      addr_o
);
  addr_t addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (launch_i) addr_q <= start_addr(base_i, imm_i, VLEN);
    else if (step_i)   addr_q <= addr_q + addr_t'(2);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ilv4_slot_mux.sv
module ilv4_slot_mux
  import ilv4_pkg::*;
#(
  parameter int unsigned VLEN   = 128,
  localparam int unsigned ELEMS = VLEN / HW_BITS,
  localparam int unsigned PBITS = VLEN / 8,
  localparam int unsigned EW    = $clog2(ELEMS)
) (
  input  logic [NREG-1:0][VLEN-1:0] vec_i,
  input  logic [PBITS-1:0]          pred_i,
  input  logic [EW-1:0]             elem_i,
  input  logic [1:0]                reg_i,
  output half_t                     data_o,
  output logic                      active_o
);
  half_t      lane [NREG][ELEMS];
  logic [ELEMS-1:0] act_bits;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
      assign lane[r][e] = vec_i[r][e*HW_BITS +: HW_BITS];
    end
  end

  // halfword element e is governed by predicate bit 2e
  for (genvar e = 0; e < ELEMS; e++) begin : g_pred
    assign act_bits[e] = pred_i[2*e];
  end

  assign data_o   = lane[reg_i][elem_i];
  assign active_o = act_bits[elem_i];
endmodule

// File: rtl/ilv4_store.sv
module ilv4_store
  import ilv4_pkg::*;
#(
  parameter int unsigned VLEN   = 128,
  localparam int unsigned ELEMS = VLEN / HW_BITS,
  localparam int unsigned PBITS = VLEN / 8,
  localparam int unsigned EW    = $clog2(ELEMS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [63:0]      base_i,
  input  logic [3:0]       imm_i,
  input  logic [PBITS-1:0] pred_i,
  input  logic [VLEN-1:0]  vec0_i,
  input  logic [VLEN-1:0]  vec1_i,
  input  logic [VLEN-1:0]  vec2_i,
  input  logic [VLEN-1:0]  vec3_i,
  input  logic             mem_ready_i,
  output logic [63:0]      mem_addr_o,
  output logic [15:0]      mem_data_o,
  output logic             mem_we_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [NREG-1:0][VLEN-1:0] vec_q;
  logic [PBITS-1:0]          pred_q;
  logic [EW-1:0]             elem;
  logic [1:0]                regi;
  logic                      busy, launch, step, active;

  assign launch = start_i && !busy;
  assign step   = busy && (!active || mem_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      pred_q <= '0;
    end else if (launch) begin
      vec_q  <= {vec3_i, vec2_i, vec1_i, vec0_i};
      pred_q <= pred_i;
    end
  end

  ilv4_seq #(.ELEMS(ELEMS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .step_i   (step),
    .elem_o   (elem),
    .reg_o    (regi),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  ilv4_addr_gen #(.VLEN(VLEN)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .step_i   (step),
    .base_i   (base_i),
    .imm_i    (imm_i),
    .addr_o   (mem_addr_o)
  );

  ilv4_slot_mux #(.VLEN(VLEN)) u_mux (
    .vec_i    (vec_q),
    .pred_i   (pred_q),
    .elem_i   (elem),
    .reg_i    (regi),
    .data_o   (mem_data_o),
    .active_o (active)
  );

  assign mem_we_o = busy && active;
  assign busy_o   = busy;
endmodule

// File: rtl/ilv4_store_chk.sv
module ilv4_store_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mem_ready_i,
  input logic [63:0] mem_addr_o,
  input logic [15:0] mem_data_o,
  input logic        mem_we_o,
  input logic        busy_o,
  input logic        done_o
);
  a_r1_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);

  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (!mem_we_o || mem_ready_i)) |=> (!busy_o || mem_addr_o == $past(mem_addr_o) + 64'd2));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_start_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind ilv4_store ilv4_store_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .mem_we_o    (mem_we_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/ilv4_store_test.sv
`timescale 1ns/1ps
module ilv4_store_test;
  localparam int unsigned VLEN  = 128;
  localparam int unsigned ELEMS = VLEN / 16;
  localparam int unsigned PBITS = VLEN / 8;
  localparam int unsigned NS    = 4 * ELEMS;

  typedef struct packed {
    logic [63:0]      base;
    logic [3:0]       imm;
    logic [PBITS-1:0] pred;
    logic [15:0]      seed;
    logic             rmode;
  } case_t;

  localparam int NCASE = 7;
  localparam case_t CASES [NCASE] = '{
    '{64'h0000_0000_0000_1000, 4'h0, 16'h5555, 16'h0100, 1'b0},
    '{64'h0000_0000_2000_0000, 4'h7, 16'h1111, 16'h2200, 1'b1},
    '{64'h0000_0000_0000_0100, 4'h8, 16'h4001, 16'h3300, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFF8, 4'h0, 16'h5555, 16'h4400, 1'b0},
    '{64'h0000_0000_0000_8000, 4'h1, 16'hAAAA, 16'h5500, 1'b1},
    '{64'h0000_0000_0000_9000, 4'h2, 16'h0000, 16'h6600, 1'b1},
    '{64'h0000_0000_00AB_C000, 4'hF, 16'h0004, 16'h7700, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mem_ready_i = 1'b0;
  logic [63:0] base_i = '0;
  logic [3:0] imm_i = '0;
  logic [PBITS-1:0] pred_i = '0;
  logic [VLEN-1:0] vec0_i = '0, vec1_i = '0, vec2_i = '0, vec3_i = '0;
  logic [63:0] mem_addr_o;
  logic [15:0] mem_data_o;
  logic mem_we_o, busy_o, done_o;

  int nchk = 0, nerr = 0;
  logic [7:0] lfsr = 8'h5B;

  always #4 clk_i = ~clk_i;

  ilv4_store #(.VLEN(VLEN)) uut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] elem_val(logic [15:0] seed, int r, int e);
    return seed + 16'(r * 4096) + 16'(e * 17);
  endfunction

  task automatic scramble();
    base_i = 64'hDEAD_BEEF_0000_0000; imm_i = 4'h3; pred_i = ~pred_i;
    vec0_i = ~vec0_i; vec1_i = {VLEN{1'b1}}; vec2_i = '0; vec3_i = vec0_i;
  endtask

  task automatic run_case(input case_t c, input int idx);
    logic [63:0] st;
    logic [63:0] prev_addr;
    bit stalled;
    int k, guard, writes;
    logic [VLEN-1:0] v [4];
    for (int r = 0; r < 4; r++)
      for (int e = 0; e < ELEMS; e++)
        v[r][16*e +: 16] = elem_val(c.seed, r, e);
    st = c.base + {{60{c.imm[3]}}, c.imm} * 64'(VLEN / 2);
    @(negedge clk_i);
    base_i = c.base; imm_i = c.imm; pred_i = c.pred;
    vec0_i = v[0]; vec1_i = v[1]; vec2_i = v[2]; vec3_i = v[3];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    scramble();
    check(busy_o === 1'b1, $sformatf("R10 busy after start case %0d", idx), 64'(busy_o), 64'd1);
    k = 0; guard = 0; writes = 0; stalled = 0; prev_addr = '0;
    while (k < NS && guard < 2000) begin
      automatic int e = k / 4;
      automatic int r = k % 4;
      automatic bit act = c.pred[2*e];
      check(busy_o === 1'b1, "R7 busy during run", 64'(busy_o), 64'd1);
      check(mem_we_o === act, act ? "R4 active slot we" : "R5 inactive slot we", 64'(mem_we_o), 64'(act));
      check(mem_addr_o === st + 64'(2 * k), k == 0 ? "R2 start address" : "R3 slot address",
            mem_addr_o, st + 64'(2 * k));
      if (stalled)
        check(mem_addr_o === prev_addr, "R6 address held on stall", mem_addr_o, prev_addr);
      if (act) begin
        check(mem_data_o === elem_val(c.seed, r, e), "R3 slot data", 64'(mem_data_o), 64'(elem_val(c.seed, r, e)));
      end
      // R8: spurious start mid-run
      start_i = (k == 3);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready_i = c.rmode ? lfsr[0] : 1'b1;
      prev_addr = mem_addr_o;
      stalled = act && !mem_ready_i;
      if (act && mem_ready_i) writes++;
      if (!act || mem_ready_i) k++;
      @(negedge clk_i);
      start_i = 1'b0;
      guard++;
    end
    check(guard < 2000, "R7 watchdog case", 64'(guard), 64'd2000);
    check(done_o === 1'b1 && busy_o === 1'b0, "R7 done after last slot", {62'd0, done_o, busy_o}, 64'd2);
    check(mem_we_o === 1'b0, "R1 no write after done", 64'(mem_we_o), 64'd0);
    if (c.pred == '0 || c.pred == 16'hAAAA)
      check(writes == 0, "R9 no writes when nothing active", 64'(writes), 64'd0);
    @(negedge clk_i);
    check(done_o === 1'b0, "R7 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #3;
    check(busy_o === 1'b0 && done_o === 1'b0 && mem_we_o === 1'b0, "R1 reset state",
          {61'd0, busy_o, done_o, mem_we_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o === 1'b0 && mem_we_o === 1'b0, "R1 idle after reset", {62'd0, busy_o, mem_we_o}, 64'd0);

    for (int i = 0; i < NCASE; i++) run_case(CASES[i], i);

    // R1: reset during an operation
    @(negedge clk_i);
    base_i = 64'h40; imm_i = 4'h0; pred_i = '1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    mem_ready_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(mem_we_o === 1'b1, "R6 stalled write stays asserted", 64'(mem_we_o), 64'd1);
    rst_ni = 1'b0;
    #1;
    check(busy_o === 1'b0 && mem_we_o === 1'b0 && done_o === 1'b0, "R1 async reset mid-run",
          {61'd0, busy_o, done_o, mem_we_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mem_ready_i = 1'b1;
    run_case(CASES[0], 99);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule